// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte Aligner

This block sits between a 32-bit data memory port and the register file of a pipelined core. For loads it takes the word returned by memory, picks out the byte, halfword or word that the access names, and then sign-extends or zero-extends it. For the left/right partial-word loads it merges the selected memory bytes into the old value of the destination register. For stores it moves the register data onto the memory lanes it targets and raises one byte-enable per lane written. The access offset comes from the two low address bits. A runtime select chooses big-endian or little-endian numbering. That select changes which lane a narrow access uses. It also changes how the left/right pair splits a misaligned word.

Lane n is bits 8n+7..8n of the memory word. In little-endian mode the byte at offset k is lane k. In big-endian mode it is lane 3-k. All results are registered: the outputs show the access presented at the previous rising clock edge. Alignment faults are not detected here. The memory array itself is outside the block.

Top module: `lsa_byte_aligner`

## Requirements
- R1: While `rst_n` is low at a rising edge, all outputs become zero. After reset, the outputs reflect the inputs sampled at the previous rising edge (one cycle of latency).
- R2: Byte loads return the byte at offset k. The lane is k in little-endian mode and 3-k in big-endian mode. Code 1 sign-extends the byte from bit 7. Code 2 fills bits 31..8 with zeros.
- R3: Halfword loads ignore address bit 0. Offset 0 covers bytes 0 and 1; offset 2 covers bytes 2 and 3. The byte at the lower address is the upper half of the value in big-endian mode and the lower half in little-endian mode. Code 3 sign-extends from bit 15. Code 4 zero-extends.
- R4: The word load (code 5) returns the memory word unchanged whatever the offset.
- R5: The left partial load (code 6) writes the most significant register bytes with memory bytes taken in ascending addresses from offset k in big-endian mode, or descending from k in little-endian mode. It writes 4-k bytes (big) or k+1 bytes (little). The other register bytes keep their old values.
- R6: The right partial load (code 7) writes the least significant register bytes with memory bytes taken in descending addresses from k in big-endian mode, or ascending from k in little-endian mode. It writes k+1 bytes (big) or 4-k bytes (little). The other register bytes keep their old values.
- R7: A byte store (code 8) enables only the lane of offset k and places store bits 7..0 there. A halfword store (code 9) enables the two lanes of its halfword and orders the two bytes as in R3. Lanes not enabled carry zero data.
- R8: A word store (code 10) asserts all four byte-enables and passes the store data unshifted.
- R9: The left partial store (code 11) and right partial store (code 12) write the same memory bytes that codes 6 and 7 would read at the same offset and endianness. They take the data from the top and bottom register bytes respectively. Only those lanes are enabled, and the other lanes carry zero data.
- R10: For loads, `wb_en` is 1 and the byte-enables and store data are zero. For stores, `wb_en` and `wb_data` are zero. Code 0 and codes 13 to 15 drive every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Access kind, codes as in R2 to R10 |
| addr_lo | input | 2 | Byte offset of the access within the word |
| big_end | input | 1 | 1 selects big-endian lane numbering, 0 selects little-endian |
| mem_rdata | input | 32 | Word read from memory |
| reg_old | input | 32 | Current value of the destination register |
| store_src | input | 32 | Register value to store |
| wb_en | output | 1 | Register write-back valid |
| wb_data | output | 32 | Aligned value to write to the register |
| byte_en | output | 4 | Per-lane store enable |
| wr_data | output | 32 | Store data shifted onto its lanes |

## Verification
The hardest cases are the partial-word pairs at the ends of the word. If the endianness fold were wrong, offset 0 in little-endian mode would replace the whole register instead of one byte, and the merge would keep the wrong old bytes. For narrow loads, sign extension is driven with bytes that have bit 7 (or bit 15) both set and clear. A design that extends from the wrong bit, or uses address bit 0 for halfwords, gives a wrong upper word. For stores, the bench checks that lanes outside the enabled set carry zero. A design that leaves shifted garbage there, or enables a mirrored lane, is caught. The idle and unused codes are driven with busy inputs, so stale or leaking output data shows up.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
// Shared access codes for the load/store aligner.
// Assumes a 4-bit access code; unlisted codes are treated as idle.
package lsa_pkg;

    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_LDB_S = 4'd1,
        OP_LDB_Z = 4'd2,
        OP_LDH_S = 4'd3,
        OP_LDH_Z = 4'd4,
        OP_LDW   = 4'd5,
        OP_LDL   = 4'd6,
        OP_LDR   = 4'd7,
        OP_STB   = 4'd8,
        OP_STH   = 4'd9,
        OP_STW   = 4'd10,
        OP_STL   = 4'd11,
        OP_STR   = 4'd12
    } lsa_op_e;

    // True for every code that writes the register file.
    function automatic logic op_is_load(input lsa_op_e op);
        return (op >= OP_LDB_S) && (op <= OP_LDR);
    endfunction

    // True for every code that writes memory.
    function automatic logic op_is_store(input lsa_op_e op);
        return (op >= OP_STB) && (op <= OP_STR);
    endfunction

endpackage

// File: rtl/lsa_lane_decode.sv
`timescale 1ns/1ps
// Turns the byte offset and the endian select into lane numbers.
// byte_lane: the lane holding the addressed byte.
// half_lane: the low lane of the addressed halfword (offset bit 0 ignored).
// eff: the offset folded so that the left/right merge logic sees big-endian
// numbering in both modes.
// Assumes LANES is a power of two, at least 4.
module lsa_lane_decode #(
    parameter int LANES = 4,
    parameter int OFS_W = $clog2(LANES)
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             big_end,
    output logic [OFS_W-1:0] byte_lane,
    output logic [OFS_W-1:0] half_lane,
    output logic [OFS_W-1:0] eff
);
    localparam logic [OFS_W-1:0] LAST   = OFS_W'(LANES - 1);
    localparam logic [OFS_W-1:0] PENULT = OFS_W'(LANES - 2);

    logic [OFS_W-1:0] half_base;

    // Mirror the offset when big-endian numbering is selected.
    always_comb begin
        half_base = {ofs[OFS_W-1:1], 1'b0};
        byte_lane = big_end ? (LAST - ofs) : ofs;
        half_lane = big_end ? (PENULT - half_base) : half_base;
        eff       = big_end ? ofs : (LAST - ofs);
    end
endmodule

// File: rtl/lsa_load_path.sv
`timescale 1ns/1ps
// Builds the register write value for every load code.
// Narrow loads shift the addressed lane(s) down and then extend them.
// Partial loads shift the memory word by the folded offset and merge it
// lane by lane with the old register value.
// Assumes the lane numbers from lsa_lane_decode; returns zero for non-loads.
module lsa_load_path
    import lsa_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  lsa_op_e                 op,
    input  logic [LANES*LANE_W-1:0] mem_word,
    input  logic [LANES*LANE_W-1:0] old_val,
    input  logic [OFS_W-1:0]        byte_lane,
    input  logic [OFS_W-1:0]        half_lane,
    input  logic [OFS_W-1:0]        eff,
    output logic [LANES*LANE_W-1:0] load_val
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int HALF_W = 2 * LANE_W;
    localparam logic [OFS_W-1:0] LAST = OFS_W'(LANES - 1);

    logic [DATA_W-1:0] byte_sh, half_sh, left_sh, right_sh;
    logic [DATA_W-1:0] left_mrg, right_mrg;
    logic [LANE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;

    // Shift the memory word for each kind of load.
    always_comb begin
        byte_sh  = mem_word >> (LANE_W * int'(byte_lane));
        half_sh  = mem_word >> (LANE_W * int'(half_lane));
        left_sh  = mem_word << (LANE_W * int'(eff));
        right_sh = mem_word >> (LANE_W * int'(LAST - eff));
        byte_v   = byte_sh[LANE_W-1:0];
        half_v   = half_sh[HALF_W-1:0];
    end

    // Per-lane choice between fresh memory data and the old register byte.
    for (genvar i = 0; i < LANES; i++) begin : g_merge
        assign left_mrg[i*LANE_W +: LANE_W] = (OFS_W'(i) >= eff) ?
            left_sh[i*LANE_W +: LANE_W] : old_val[i*LANE_W +: LANE_W];
        assign right_mrg[i*LANE_W +: LANE_W] = (OFS_W'(i) <= eff) ?
            right_sh[i*LANE_W +: LANE_W] : old_val[i*LANE_W +: LANE_W];
    end

    // Pick the result for the access code and apply extension.
    always_comb begin
        unique case (op)
            OP_LDB_S: load_val = {{(DATA_W-LANE_W){byte_v[LANE_W-1]}}, byte_v};
            OP_LDB_Z: load_val = {{(DATA_W-LANE_W){1'b0}}, byte_v};
            OP_LDH_S: load_val = {{(DATA_W-HALF_W){half_v[HALF_W-1]}}, half_v};
            OP_LDH_Z: load_val = {{(DATA_W-HALF_W){1'b0}}, half_v};
            OP_LDW:   load_val = mem_word;
            OP_LDL:   load_val = left_mrg;
            OP_LDR:   load_val = right_mrg;
            default:  load_val = '0;
        endcase
    end
endmodule

// File: rtl/lsa_store_path.sv
`timescale 1ns/1ps
// Builds byte-enables and lane-placed store data for every store code.
// Lanes that are not enabled carry zero data.
// Assumes the lane numbers from lsa_lane_decode; returns zero for non-stores.
module lsa_store_path
    import lsa_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  lsa_op_e                 op,
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [OFS_W-1:0]        byte_lane,
    input  logic [OFS_W-1:0]        half_lane,
    input  logic [OFS_W-1:0]        eff,
    output logic [LANES-1:0]        be,
    output logic [LANES*LANE_W-1:0] data
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int HALF_W = 2 * LANE_W;
    localparam logic [OFS_W-1:0] LAST = OFS_W'(LANES - 1);
    localparam logic [LANES-1:0] ALL  = {LANES{1'b1}};

    // Place the data and raise the enables for the access code.
    always_comb begin
        unique case (op)
            OP_STB: begin
                be   = LANES'(1) << byte_lane;
                data = DATA_W'(src[LANE_W-1:0]) << (LANE_W * int'(byte_lane));
            end
            OP_STH: begin
                be   = LANES'(3) << half_lane;
                data = DATA_W'(src[HALF_W-1:0]) << (LANE_W * int'(half_lane));
            end
            OP_STW: begin
                be   = ALL;
                data = src;
            end
            OP_STL: begin
                be   = ALL >> eff;
                data = src >> (LANE_W * int'(eff));
            end
            OP_STR: begin
                be   = ALL << (LAST - eff);
                data = src << (LANE_W * int'(LAST - eff));
            end
            default: begin
                be   = '0;
                data = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsa_byte_aligner.sv
`timescale 1ns/1ps
// Endian-aware load/store aligner, registered outputs.
// Decodes the offset, runs the load and store paths in parallel and
// registers the result selected by the access class.
// Assumes no alignment checking is wanted; halfword offsets ignore bit 0
// and word accesses ignore the offset.
module lsa_byte_aligner
    import lsa_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  op_code,
    input  logic [$clog2(LANES)-1:0]    addr_lo,
    input  logic                        big_end,
    input  logic [LANES*LANE_W-1:0]     mem_rdata,
    input  logic [LANES*LANE_W-1:0]     reg_old,
    input  logic [LANES*LANE_W-1:0]     store_src,
    output logic                        wb_en,
    output logic [LANES*LANE_W-1:0]     wb_data,
    output logic [LANES-1:0]            byte_en,
    output logic [LANES*LANE_W-1:0]     wr_data
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int OFS_W  = $clog2(LANES);

    lsa_op_e           op_e;
    logic              is_ld;
    logic [OFS_W-1:0]  byte_lane, half_lane, eff;
    logic [DATA_W-1:0] ld_val, st_data;
    logic [LANES-1:0]  st_be;

    assign op_e  = lsa_op_e'(op_code);
    assign is_ld = op_is_load(op_e);

    lsa_lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) u_decode (
        .ofs       (addr_lo),
        .big_end   (big_end),
        .byte_lane (byte_lane),
        .half_lane (half_lane),
        .eff       (eff)
    );

    lsa_load_path #(.LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W)) u_load (
        .op        (op_e),
        .mem_word  (mem_rdata),
        .old_val   (reg_old),
        .byte_lane (byte_lane),
        .half_lane (half_lane),
        .eff       (eff),
        .load_val  (ld_val)
    );

    lsa_store_path #(.LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W)) u_store (
        .op        (op_e),
        .src       (store_src),
        .byte_lane (byte_lane),
        .half_lane (half_lane),
        .eff       (eff),
        .be        (st_be),
        .data      (st_data)
    );

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_data <= '0;
            byte_en <= '0;
            wr_data <= '0;
        end else begin
            wb_en   <= is_ld;
            wb_data <= is_ld ? ld_val : '0;
            byte_en <= st_be;
            wr_data <= st_data;
        end
    end

    // R8: a full word store enables every lane and keeps the data in place.
    assert_word_store_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_STW) |-> ((st_be == {LANES{1'b1}}) && (st_data == store_src)));

    // R7: a byte store writes exactly one lane.
    assert_byte_store_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_STB) |-> $onehot(st_be));

    // R9: the left store always reaches lane 0, the right store the top lane.
    assert_partial_store_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_e == OP_STL) |-> st_be[0]) and ((op_e == OP_STR) |-> st_be[LANES-1]));

    // R10: a load never drives store enables, registered or not.
    assert_load_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ld |-> (st_be == '0)) and (wb_en |-> (byte_en == '0)));

    // R2: a zero-extended byte load leaves the upper bits clear.
    assert_byte_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_LDB_Z) |-> (ld_val[DATA_W-1:LANE_W] == '0));
endmodule

// File: tb/lsa_byte_aligner_bench.sv
`timescale 1ns/1ps
module lsa_byte_aligner_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_code;
    logic [1:0]  addr_lo;
    logic        big_end;
    logic [31:0] mem_rdata, reg_old, store_src;
    logic        wb_en;
    logic [31:0] wb_data, wr_data;
    logic [3:0]  byte_en;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [31:0] PAT_A = 32'h8A3CF147;
    localparam logic [31:0] PAT_B = 32'h7EC519B2;
    localparam logic [31:0] OLD_V = 32'h55667788;
    localparam logic [31:0] SRC_V = 32'hC3A59617;

    always #2.5 clk = ~clk;

    lsa_byte_aligner u_lsa_byte_aligner (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .addr_lo(addr_lo),
        .big_end(big_end), .mem_rdata(mem_rdata), .reg_old(reg_old),
        .store_src(store_src), .wb_en(wb_en), .wb_data(wb_data),
        .byte_en(byte_en), .wr_data(wr_data)
    );

    function automatic int lane_of(input int a, input bit big);
        return big ? 3 - a : a;
    endfunction

    function automatic logic [7:0] mbyte(input logic [31:0] w, input int a, input bit big);
        logic [31:0] t;
        t = w >> (8 * lane_of(a, big));
        return t[7:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
    task automatic apply(input logic [3:0] op, input int k, input bit big,
                         input logic [31:0] mem, input logic [31:0] old, input logic [31:0] src);
        op_code = op; addr_lo = 2'(k); big_end = big;
        mem_rdata = mem; reg_old = old; store_src = src;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_all(input string tag, input bit en, input logic [31:0] wb,
                              input logic [3:0] be, input logic [31:0] wd);
        check({tag, " wb_en"}, 32'(wb_en), 32'(en));
        check({tag, " wb_data"}, wb_data, wb);
        check({tag, " byte_en"}, 32'(byte_en), 32'(be));
        check({tag, " wr_data"}, wr_data, wd);
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        op_code = 4'd10; addr_lo = 2'd1; big_end = 1'b1;
        mem_rdata = PAT_A; reg_old = OLD_V; store_src = SRC_V;
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_all("R1 in reset", 1'b0, 32'h0, 4'h0, 32'h0);
        rst_n = 1'b1;
        op_code = 4'd5; mem_rdata = PAT_B;
        #1;
        check("R1 no change before edge", wb_data, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R1 one cycle latency", wb_data, PAT_B);
    endtask

    task automatic test_byte_loads;
        for (int p = 0; p < 2; p++)
            for (int big = 0; big < 2; big++)
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] mem;
                    logic [7:0]  b;
                    mem = (p == 0) ? PAT_A : PAT_B;
                    b = mbyte(mem, k, big[0]);
                    apply(4'd1, k, big[0], mem, OLD_V, SRC_V);
                    expect_all($sformatf("R2 sext big=%0d k=%0d", big, k), 1'b1,
                               {{24{b[7]}}, b}, 4'h0, 32'h0);
                    apply(4'd2, k, big[0], mem, OLD_V, SRC_V);
                    expect_all($sformatf("R2 zext big=%0d k=%0d", big, k), 1'b1,
                               {24'h0, b}, 4'h0, 32'h0);
                end
    endtask

    task automatic test_half_loads;
        for (int p = 0; p < 2; p++)
            for (int big = 0; big < 2; big++)
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] mem;
                    logic [15:0] h;
                    int a0;
                    mem = (p == 0) ? PAT_A : PAT_B;
                    a0 = k & 2;
                    h = big ? {mbyte(mem, a0, 1'b1), mbyte(mem, a0 + 1, 1'b1)}
                            : {mbyte(mem, a0 + 1, 1'b0), mbyte(mem, a0, 1'b0)};
                    apply(4'd3, k, big[0], mem, OLD_V, SRC_V);
                    expect_all($sformatf("R3 sext big=%0d k=%0d", big, k), 1'b1,
                               {{16{h[15]}}, h}, 4'h0, 32'h0);
                    apply(4'd4, k, big[0], mem, OLD_V, SRC_V);
                    expect_all($sformatf("R3 zext big=%0d k=%0d", big, k), 1'b1,
                               {16'h0, h}, 4'h0, 32'h0);
                end
    endtask

    task automatic test_word_load;
        for (int big = 0; big < 2; big++)
            for (int k = 0; k < 4; k++) begin
                apply(4'd5, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R4 big=%0d k=%0d", big, k), 1'b1, PAT_A, 4'h0, 32'h0);
            end
    endtask

    task automatic test_load_left;
        for (int big = 0; big < 2; big++)
            for (int k = 0; k < 4; k++) begin
                logic [31:0] r;
                int n;
                r = OLD_V;
                n = big ? 4 - k : k + 1;
                for (int j = 0; j < n; j++)
                    r[8*(3-j) +: 8] = mbyte(PAT_A, big ? k + j : k - j, big[0]);
                apply(4'd6, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R5 big=%0d k=%0d", big, k), 1'b1, r, 4'h0, 32'h0);
            end
    endtask

    task automatic test_load_right;
        for (int big = 0; big < 2; big++)
            for (int k = 0; k < 4; k++) begin
                logic [31:0] r;
                int n;
                r = OLD_V;
                n = big ? k + 1 : 4 - k;
                for (int j = 0; j < n; j++)
                    r[8*j +: 8] = mbyte(PAT_A, big ? k - j : k + j, big[0]);
                apply(4'd7, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R6 big=%0d k=%0d", big, k), 1'b1, r, 4'h0, 32'h0);
            end
    endtask

    task automatic test_narrow_stores;
        for (int big = 0; big < 2; big++)
            for (int k = 0; k < 4; k++) begin
                logic [3:0]  be;
                logic [31:0] d;
                int a0, la, lb;
                la = lane_of(k, big[0]);
                be = 4'h0; d = 32'h0;
                be[la] = 1'b1; d[8*la +: 8] = SRC_V[7:0];
                apply(4'd8, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R7 byte big=%0d k=%0d", big, k), 1'b0, 32'h0, be, d);
                a0 = k & 2;
                la = lane_of(a0, big[0]); lb = lane_of(a0 + 1, big[0]);
                be = 4'h0; d = 32'h0;
                be[la] = 1'b1; be[lb] = 1'b1;
                d[8*la +: 8] = big ? SRC_V[15:8] : SRC_V[7:0];
                d[8*lb +: 8] = big ? SRC_V[7:0] : SRC_V[15:8];
                apply(4'd9, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R7 half big=%0d k=%0d", big, k), 1'b0, 32'h0, be, d);
            end
    endtask

    task automatic test_word_store;
        for (int big = 0; big < 2; big++)
            for (int k = 0; k < 4; k++) begin
                apply(4'd10, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R8 big=%0d k=%0d", big, k), 1'b0, 32'h0, 4'hF, SRC_V);
            end
    endtask

    task automatic test_partial_stores;
        for (int big = 0; big < 2; big++)
            for (int k = 0; k < 4; k++) begin
                logic [3:0]  be;
                logic [31:0] d;
                int n, ln;
                be = 4'h0; d = 32'h0;
                n = big ? 4 - k : k + 1;
                for (int j = 0; j < n; j++) begin
                    ln = lane_of(big ? k + j : k - j, big[0]);
                    be[ln] = 1'b1;
                    d[8*ln +: 8] = SRC_V[8*(3-j) +: 8];
                end
                apply(4'd11, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R9 left big=%0d k=%0d", big, k), 1'b0, 32'h0, be, d);
                be = 4'h0; d = 32'h0;
                n = big ? k + 1 : 4 - k;
                for (int j = 0; j < n; j++) begin
                    ln = lane_of(big ? k - j : k + j, big[0]);
                    be[ln] = 1'b1;
                    d[8*ln +: 8] = SRC_V[8*j +: 8];
                end
                apply(4'd12, k, big[0], PAT_A, OLD_V, SRC_V);
                expect_all($sformatf("R9 right big=%0d k=%0d", big, k), 1'b0, 32'h0, be, d);
            end
    endtask

    task automatic test_idle_codes;
        logic [3:0] codes [4] = '{4'd0, 4'd13, 4'd14, 4'd15};
        for (int c = 0; c < 4; c++) begin
            apply(4'd10, 1, 1'b0, PAT_B, OLD_V, SRC_V);
            apply(codes[c], c, 1'b1, PAT_A, OLD_V, SRC_V);
            expect_all($sformatf("R10 idle code=%0d", codes[c]), 1'b0, 32'h0, 4'h0, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        test_reset;
        test_byte_loads;
        test_half_loads;
        test_word_load;
        test_load_left;
        test_load_right;
        test_narrow_stores;
        test_word_store;
        test_partial_stores;
        test_idle_codes;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule